// File: doc/BRIEF.md
# Entropy Seed CSR Access Unit

This block answers processor accesses to a single 32-bit entropy seed register in the CSR space. When the processor presents an access, the unit decides whether the access is allowed. It uses the current privilege level, the virtualization flag, the global enable for the entropy extension, and two enable bits taken from the machine security configuration register. The result is either a status-tagged entropy word or an exception code.

The register holds no stored contents. Each permitted access reports the current operating state of the entropy source in a 2-bit status field. When a fresh 16-bit sample is ready, the access takes that sample from the source through a pop strobe and returns it. A response appears one clock after the request. Accesses to any other CSR address are left to the rest of the CSR file, and this unit stays silent for them.

Top module: `seed_csr_unit`

## Requirements
- R1: A request whose address equals the seed address (default 0x015) produces exactly one response, with `rsp_valid_o` high in the cycle after the request. A request to any other address produces no response and no pop.
- R2: When `ext_en_i` is low, every access to the seed address returns exception code 01 (illegal instruction) with data zero.
- R3: Access kinds are encoded on `csr_kind_i` as 00 swap, 01 set, 10 clear and 11 reserved. A set or clear whose source is zero (`csr_src_nz_i` low) is read-only and returns code 01. A reserved kind also returns code 01.
- R4: Privilege is encoded on `priv_i` as 00 user, 01 supervisor and 11 machine. Machine mode is always granted, whatever the virtualization flag and the enable bits are.
- R5: Outside virtualization, supervisor mode is granted only when bit 9 of `sec_cfg_i` is set, and user mode only when bit 8 is set. Privilege value 10 is never granted. Every refusal returns code 01.
- R6: With `virt_i` high and a privilege other than machine, the access returns code 10 (virtual instruction fault) when bit 9 of `sec_cfg_i` is set, and code 01 when it is clear.
- R7: A granted access with a sample ready returns status 10 in bits 31:30 and the sample in bits 15:0. Bits 29:16 are zero in every response.
- R8: A granted access with no sample ready, and with the source neither dead nor in self-test, returns status 01 (wait) with bits 15:0 zero.
- R9: The source conditions have a fixed priority: dead (status 11) beats self-test (status 00), which beats a ready sample. Both dead and self-test responses carry zero low bits.
- R10: `es_pop_o` is high in the request cycle exactly when the access is granted and returns status 10. A faulting response carries exception code zero data and pops nothing.
- R11: The write data on `csr_wdata_i` has no effect on the response, including for a swap used only as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_req_i | input | 1 | CSR access request strobe |
| csr_addr_i | input | 12 | CSR address |
| csr_kind_i | input | 2 | Access kind: 00 swap, 01 set, 10 clear, 11 reserved |
| csr_src_nz_i | input | 1 | Source register or immediate is non-zero |
| csr_wdata_i | input | 32 | Write data (ignored) |
| priv_i | input | 2 | Privilege: 00 user, 01 supervisor, 11 machine |
| virt_i | input | 1 | Virtualization mode active |
| ext_en_i | input | 1 | Entropy extension enabled |
| sec_cfg_i | input | 32 | Machine security configuration (bit 8 user enable, bit 9 supervisor enable) |
| es_valid_i | input | 1 | Entropy source holds a fresh sample |
| es_data_i | input | 16 | Entropy sample |
| es_bist_i | input | 1 | Entropy source in self-test |
| es_dead_i | input | 1 | Entropy source failed unrecoverably |
| es_pop_o | output | 1 | Sample consumed this cycle |
| rsp_valid_o | output | 1 | Response valid |
| rsp_data_o | output | 32 | Response word |
| rsp_exc_o | output | 2 | Exception: 00 none, 01 illegal instruction, 10 virtual instruction fault |

## Verification
The assertions take for granted three things about the inputs. The request and entropy-source inputs are free of X. The entropy status flags and sample hold steady for the whole request cycle. The sample that a pop consumes is the value present on `es_data_i` in that same cycle. The stimulus meets these conditions by changing every input only on the falling clock edge. It also sets the source state as part of each access, so the flags never move within a cycle. Idle cycles drop the request and clear the source flags. This keeps the no-response checks free of stray pops.

// File: rtl/seed_pkg.sv
package seed_pkg;

    typedef enum logic [1:0] {
        EXC_NONE    = 2'b00,
        EXC_ILLEGAL = 2'b01,
        EXC_VIRT    = 2'b10
    } exc_e;

    typedef enum logic [1:0] {
        ST_BIST = 2'b00,
        ST_WAIT = 2'b01,
        ST_ES16 = 2'b10,
        ST_DEAD = 2'b11
    } opst_e;

    typedef enum logic [1:0] {
        KIND_SWAP  = 2'b00,
        KIND_SET   = 2'b01,
        KIND_CLEAR = 2'b10,
        KIND_RSVD  = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        PRV_USER  = 2'b00,
        PRV_SUPER = 2'b01,
        PRV_RSVD  = 2'b10,
        PRV_MACH  = 2'b11
    } priv_e;

endpackage

// File: rtl/seed_perm.sv
module seed_perm #(
    parameter int CFG_W   = 32,
    parameter int UEN_BIT = 8,
    parameter int SEN_BIT = 9
) (
    input  logic             ext_en,
    input  logic [1:0]       kind,
    input  logic             src_nz,
    input  logic [1:0]       priv,
    input  logic             virt,
    input  logic [CFG_W-1:0] cfg,
    output logic [1:0]       exc
);
    import seed_pkg::*;

    logic writes;
    logic sup_en;
    logic usr_en;

    always_comb begin
        sup_en = cfg[SEN_BIT];
        usr_en = cfg[UEN_BIT];
        unique case (kind_e'(kind))
            KIND_SWAP:             writes = 1'b1;
            KIND_SET, KIND_CLEAR:  writes = src_nz;
            default:               writes = 1'b0;
        endcase

        if (!ext_en || !writes) begin
            exc = EXC_ILLEGAL;
        end else if (priv_e'(priv) == PRV_MACH) begin
            exc = EXC_NONE;
        end else if (virt) begin
            exc = sup_en ? EXC_VIRT : EXC_ILLEGAL;
        end else if (priv_e'(priv) == PRV_SUPER && sup_en) begin
            exc = EXC_NONE;
        end else if (priv_e'(priv) == PRV_USER && usr_en) begin
            exc = EXC_NONE;
        end else begin
            exc = EXC_ILLEGAL;
        end
    end

endmodule

// File: rtl/seed_fmt.sv
module seed_fmt #(
    parameter int XLEN     = 32,
    parameter int SAMPLE_W = 16
) (
    input  logic                es_valid,
    input  logic                es_bist,
    input  logic                es_dead,
    input  logic [SAMPLE_W-1:0] es_data,
    output logic [XLEN-1:0]     word,
    output logic                fresh
);
    import seed_pkg::*;

    localparam int ST_LSB = XLEN - 2;
    localparam int PAD_W  = ST_LSB - SAMPLE_W;

    opst_e               st;
    logic [SAMPLE_W-1:0] low;

    always_comb begin
        if (es_dead)       st = ST_DEAD;
        else if (es_bist)  st = ST_BIST;
        else if (es_valid) st = ST_ES16;
        else               st = ST_WAIT;
        fresh = (st == ST_ES16);
        low   = fresh ? es_data : '0;
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign word = {st, {PAD_W{1'b0}}, low};
        end else begin : g_nopad
            assign word = {st, low};
        end
    endgenerate

endmodule

// File: rtl/seed_csr_unit.sv
module seed_csr_unit #(
    parameter int          XLEN      = 32,
    parameter int          ADDR_W    = 12,
    parameter logic [11:0] SEED_ADDR = 12'h015,
    parameter int          SAMPLE_W  = 16,
    parameter int          UEN_BIT   = 8,
    parameter int          SEN_BIT   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_req_i,
    input  logic [ADDR_W-1:0] csr_addr_i,
    input  logic [1:0]        csr_kind_i,
    input  logic              csr_src_nz_i,
    input  logic [XLEN-1:0]   csr_wdata_i,
    input  logic [1:0]        priv_i,
    input  logic              virt_i,
    input  logic              ext_en_i,
    input  logic [XLEN-1:0]   sec_cfg_i,
    input  logic              es_valid_i,
    input  logic [SAMPLE_W-1:0] es_data_i,
    input  logic              es_bist_i,
    input  logic              es_dead_i,
    output logic              es_pop_o,
    output logic              rsp_valid_o,
    output logic [XLEN-1:0]   rsp_data_o,
    output logic [1:0]        rsp_exc_o
);
    import seed_pkg::*;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] data;
        logic [1:0]      exc;
    } rsp_t;

    rsp_t            rsp_d, rsp_q;
    logic [1:0]      perm_exc;
    logic [XLEN-1:0] fmt_word;
    logic            fmt_fresh;
    logic            hit;
    logic            granted;
    logic            wdata_unused;

    assign wdata_unused = ^csr_wdata_i;

    seed_perm #(
        .CFG_W   (XLEN),
        .UEN_BIT (UEN_BIT),
        .SEN_BIT (SEN_BIT)
    ) u_perm (
        .ext_en (ext_en_i),
        .kind   (csr_kind_i),
        .src_nz (csr_src_nz_i),
        .priv   (priv_i),
        .virt   (virt_i),
        .cfg    (sec_cfg_i),
        .exc    (perm_exc)
    );

    seed_fmt #(
        .XLEN     (XLEN),
        .SAMPLE_W (SAMPLE_W)
    ) u_fmt (
        .es_valid (es_valid_i),
        .es_bist  (es_bist_i),
        .es_dead  (es_dead_i),
        .es_data  (es_data_i),
        .word     (fmt_word),
        .fresh    (fmt_fresh)
    );

    always_comb begin
        hit       = csr_req_i && (csr_addr_i == ADDR_W'(SEED_ADDR));
        granted   = hit && (perm_exc == EXC_NONE);
        rsp_d       = '0;
        rsp_d.valid = hit;
        rsp_d.exc   = hit ? perm_exc : EXC_NONE;
        rsp_d.data  = granted ? fmt_word : '0;
        es_pop_o    = granted && fmt_fresh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid_o = rsp_q.valid;
    assign rsp_data_o  = rsp_q.data;
    assign rsp_exc_o   = rsp_q.exc;

endmodule

// File: rtl/seed_csr_unit_chk.sv
module seed_csr_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        csr_req_i,
    input logic [11:0] csr_addr_i,
    input logic [1:0]  csr_kind_i,
    input logic        csr_src_nz_i,
    input logic [1:0]  priv_i,
    input logic        ext_en_i,
    input logic        es_valid_i,
    input logic [15:0] es_data_i,
    input logic        es_bist_i,
    input logic        es_dead_i,
    input logic        es_pop_o,
    input logic        rsp_valid_o,
    input logic [31:0] rsp_data_o,
    input logic [1:0]  rsp_exc_o
);
    logic at_seed;
    logic writes;
    assign at_seed = csr_req_i && (csr_addr_i == 12'h015);
    assign writes  = (csr_kind_i == 2'b00) ||
                     ((csr_kind_i == 2'b01 || csr_kind_i == 2'b10) && csr_src_nz_i);

    // R1
    p_silent_off_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !at_seed |=> !rsp_valid_o);
    p_answer_on_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        at_seed |=> rsp_valid_o);
    // R2
    p_ext_off_illegal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (at_seed && !ext_en_i) |=> (rsp_exc_o == 2'b01));
    // R3
    p_readonly_illegal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (at_seed && !writes) |=> (rsp_exc_o == 2'b01));
    // R4
    p_machine_granted_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (at_seed && ext_en_i && writes && priv_i == 2'b11) |=> (rsp_exc_o == 2'b00));
    // R7
    p_mid_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> (rsp_data_o[29:16] == 14'd0));
    // R9
    p_low_zero_unless_es16_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_data_o[31:30] != 2'b10) |-> (rsp_data_o[15:0] == 16'd0));
    // R10
    p_pop_returns_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
        es_pop_o |=> (rsp_valid_o && rsp_exc_o == 2'b00 && rsp_data_o[31:30] == 2'b10
                      && rsp_data_o[15:0] == $past(es_data_i)));
    p_pop_needs_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
        es_pop_o |-> (at_seed && es_valid_i && !es_bist_i && !es_dead_i));
    p_fault_no_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_exc_o != 2'b00) |-> (rsp_data_o == 32'd0));

endmodule

bind seed_csr_unit seed_csr_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .csr_req_i    (csr_req_i),
    .csr_addr_i   (csr_addr_i),
    .csr_kind_i   (csr_kind_i),
    .csr_src_nz_i (csr_src_nz_i),
    .priv_i       (priv_i),
    .ext_en_i     (ext_en_i),
    .es_valid_i   (es_valid_i),
    .es_data_i    (es_data_i),
    .es_bist_i    (es_bist_i),
    .es_dead_i    (es_dead_i),
    .es_pop_o     (es_pop_o),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_data_o   (rsp_data_o),
    .rsp_exc_o    (rsp_exc_o)
);

// File: tb/seed_csr_unit_tb.sv
module seed_csr_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_req_i = 1'b0;
    logic [11:0] csr_addr_i = '0;
    logic [1:0]  csr_kind_i = '0;
    logic        csr_src_nz_i = 1'b0;
    logic [31:0] csr_wdata_i = '0;
    logic [1:0]  priv_i = '0;
    logic        virt_i = 1'b0;
    logic        ext_en_i = 1'b0;
    logic [31:0] sec_cfg_i = '0;
    logic        es_valid_i = 1'b0;
    logic [15:0] es_data_i = '0;
    logic        es_bist_i = 1'b0;
    logic        es_dead_i = 1'b0;
    logic        es_pop_o;
    logic        rsp_valid_o;
    logic [31:0] rsp_data_o;
    logic [1:0]  rsp_exc_o;

    always #2 clk = ~clk;

    seed_csr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .csr_req_i(csr_req_i), .csr_addr_i(csr_addr_i),
        .csr_kind_i(csr_kind_i), .csr_src_nz_i(csr_src_nz_i), .csr_wdata_i(csr_wdata_i),
        .priv_i(priv_i), .virt_i(virt_i), .ext_en_i(ext_en_i), .sec_cfg_i(sec_cfg_i),
        .es_valid_i(es_valid_i), .es_data_i(es_data_i), .es_bist_i(es_bist_i),
        .es_dead_i(es_dead_i), .es_pop_o(es_pop_o), .rsp_valid_o(rsp_valid_o),
        .rsp_data_o(rsp_data_o), .rsp_exc_o(rsp_exc_o)
    );

    localparam logic [1:0] U = 2'b00, S = 2'b01, RP = 2'b10, M = 2'b11;
    localparam logic [1:0] SWAP = 2'b00, SET = 2'b01, CLR = 2'b10, RSV = 2'b11;
    localparam logic [31:0] EN_U = 32'h100, EN_S = 32'h200, EN_B = 32'h300;

    typedef struct {
        logic        valid;
        logic [31:0] data;
        logic [1:0]  exc;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;

    task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: applies one access, checks the same-cycle pop, queues the response.
    task automatic issue(input string tag, input logic [11:0] addr, input logic [1:0] kind,
                         input logic srcnz, input logic [1:0] priv, input logic virt,
                         input logic [31:0] cfg, input logic ext, input logic esv,
                         input logic [15:0] esd, input logic bist, input logic dead,
                         input logic [31:0] wdata);
        exp_t e;
        logic wr;
        logic [1:0] x;
        logic [31:0] d;
        @(negedge clk);
        csr_req_i = 1'b1; csr_addr_i = addr; csr_kind_i = kind; csr_src_nz_i = srcnz;
        priv_i = priv; virt_i = virt; sec_cfg_i = cfg; ext_en_i = ext;
        es_valid_i = esv; es_data_i = esd; es_bist_i = bist; es_dead_i = dead;
        csr_wdata_i = wdata;
        wr = (kind == SWAP) || ((kind == SET || kind == CLR) && srcnz);
        if (!ext || !wr)                 x = 2'b01;
        else if (priv == M)              x = 2'b00;
        else if (virt)                   x = cfg[9] ? 2'b10 : 2'b01;
        else if (priv == S && cfg[9])    x = 2'b00;
        else if (priv == U && cfg[8])    x = 2'b00;
        else                             x = 2'b01;
        if (x != 2'b00) d = 32'h0;
        else if (dead)  d = 32'hC000_0000;
        else if (bist)  d = 32'h0000_0000;
        else if (esv)   d = {16'h8000, esd};
        else            d = 32'h4000_0000;
        e.valid = (addr == 12'h015);
        e.exc   = e.valid ? x : 2'b00;
        e.data  = e.valid ? d : 32'h0;
        e.tag   = tag;
        exp_q.push_back(e);
        #1;
        check({tag, " R10 pop"}, {33'd0, es_pop_o},
              {33'd0, e.valid && x == 2'b00 && !dead && !bist && esv});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            csr_req_i = 1'b0; es_valid_i = 1'b0; es_bist_i = 1'b0; es_dead_i = 1'b0;
        end
    endtask

    // Monitor: compares each registered response against the queue.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                if (exp_q.size() > 0) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(e.tag, {rsp_valid_o, rsp_exc_o, rsp_data_o[30:0]} ,
                          {e.valid, e.exc, e.data[30:0]});
                    if (e.valid) check({e.tag, " top bit"}, {33'd0, rsp_data_o[31]},
                                       {33'd0, e.data[31]});
                end else if (rsp_valid_o) begin
                    check("R1 unexpected response", {33'd0, rsp_valid_o}, 34'd0);
                end
            end
        end
    end

    task automatic run();
        repeat (3) @(negedge clk);
        check("R1 reset state", {32'd0, rsp_valid_o, es_pop_o}, 34'd0);
        rst_n = 1'b1;
        // R4 machine grants, ES16 layout R7
        issue("R4 R7 machine es16", 12'h015, SWAP, 1, M, 0, 0, 1, 1, 16'hA5C3, 0, 0, 0);
        issue("R4 machine virt",    12'h015, SET,  1, M, 1, 0, 1, 1, 16'h1234, 0, 0, 0);
        issue("R7 full sample",     12'h015, CLR,  1, M, 0, 0, 1, 1, 16'hFFFF, 0, 0, 32'hFFFF_FFFF);
        // R8 wait
        issue("R8 wait",            12'h015, SWAP, 1, M, 0, 0, 1, 0, 16'hBEEF, 0, 0, 0);
        // R9 priority
        issue("R9 bist",            12'h015, SWAP, 1, M, 0, 0, 1, 1, 16'h5555, 1, 0, 0);
        issue("R9 dead",            12'h015, SWAP, 1, M, 0, 0, 1, 1, 16'h7777, 0, 1, 0);
        issue("R9 dead over bist",  12'h015, SWAP, 1, M, 0, 0, 1, 1, 16'h7777, 1, 1, 0);
        // R1 decode
        issue("R1 other address",   12'h016, SWAP, 1, M, 0, 0, 1, 1, 16'h4321, 0, 0, 0);
        issue("R1 neighbour low",   12'h014, SWAP, 1, M, 0, 0, 1, 1, 16'h4321, 0, 0, 0);
        idle(1);
        // R2
        issue("R2 ext disabled",    12'h015, SWAP, 1, M, 0, EN_B, 0, 1, 16'h0F0F, 0, 0, 0);
        // R3
        issue("R3 set zero src",    12'h015, SET,  0, M, 0, 0, 1, 1, 16'h0F0F, 0, 0, 0);
        issue("R3 clear zero src",  12'h015, CLR,  0, M, 0, 0, 1, 1, 16'h0F0F, 0, 0, 0);
        issue("R3 reserved kind",   12'h015, RSV,  1, M, 0, 0, 1, 1, 16'h0F0F, 0, 0, 0);
        issue("R3 swap no src",     12'h015, SWAP, 0, M, 0, 0, 1, 1, 16'h0A0A, 0, 0, 0);
        // R5
        issue("R5 super enabled",   12'h015, SWAP, 1, S, 0, EN_S, 1, 1, 16'h1111, 0, 0, 0);
        issue("R5 super disabled",  12'h015, SWAP, 1, S, 0, EN_U, 1, 1, 16'h1111, 0, 0, 0);
        issue("R5 user enabled",    12'h015, SWAP, 1, U, 0, EN_U, 1, 1, 16'h2222, 0, 0, 0);
        issue("R5 user disabled",   12'h015, SWAP, 1, U, 0, EN_S, 1, 1, 16'h2222, 0, 0, 0);
        issue("R5 reserved priv",   12'h015, SWAP, 1, RP, 0, EN_B, 1, 1, 16'h2222, 0, 0, 0);
        issue("R5 super wait",      12'h015, SET,  1, S, 0, EN_B, 1, 0, 16'h0, 0, 0, 0);
        // R6
        issue("R6 vs with sen",     12'h015, SWAP, 1, S, 1, EN_S, 1, 1, 16'h3333, 0, 0, 0);
        issue("R6 vs without sen",  12'h015, SWAP, 1, S, 1, EN_U, 1, 1, 16'h3333, 0, 0, 0);
        issue("R6 vu with sen",     12'h015, SWAP, 1, U, 1, EN_B, 1, 1, 16'h3333, 0, 0, 0);
        issue("R6 vu user only",    12'h015, SWAP, 1, U, 1, EN_U, 1, 1, 16'h3333, 0, 0, 0);
        // R11 write data ignored
        issue("R11 wdata ones",     12'h015, SWAP, 1, M, 0, 0, 1, 1, 16'h6C6C, 0, 0, 32'hFFFF_FFFF);
        issue("R11 wdata pattern",  12'h015, SWAP, 1, M, 0, 0, 1, 0, 16'h0, 0, 0, 32'h8000_1234);
        idle(3);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (20000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule